// File: doc/BRIEF.md
# Rolling shutter row sequencer

This block schedules the row operations of an electronic rolling shutter over a programmable band of rows. Two pointers walk the window. The reset pointer clears one row on every row-period tick. The read pointer follows it at a distance equal to the integration time. The read pointer reports each row it visits, marks the end of each frame, and signals when a capture has finished. A surrounding timing controller supplies the row-period tick and uses the strobes to drive the row decoders and the column pipeline.

The block starts on a rising edge of `run` and runs in one of two modes. In single-frame mode it captures one frame. In continuous mode it loops over frames until `run` is lowered. There are two ways to stop. A graceful stop lets the current frame finish. An abrupt stop ends the run at once. The window is taken at each frame start, and the integration time is taken once per run, so register writes made in the middle of a frame never break the frame in progress. All ports are plain level or pulse signals. The block has no streaming data path, so it has no back-pressure.

Top module: `rolling_row_seq`

## Requirements
- R1: When idle, a rising edge on `run` with a valid window raises `busy` at the next clock edge. The first tick after that resets the aligned first row, which is `first_row` with bits [1:0] cleared.
- R2: While a frame is being reset, every accepted tick gives one `rst_stb` pulse for the next row, ending at `last_row`. Rows come out in ascending order, one per tick, and `rst_stb` follows the tick by one cycle.
- R3: A row reset on tick t is read on tick t+K, where K is `integ_rows` captured at the start of the run, and a value of 0 counts as 1. No read occurs during the first K ticks of a run.
- R4: The frame period is max(N, K) ticks, where N is the number of rows in the window. When K > N, the reset pointer stays idle for K-N ticks before the next frame starts, and the reads keep the same gap.
- R5: In continuous mode, the reset pointer moves from the bottom row back to the top of the window. The window inputs are sampled again when each new frame starts. If the new window is invalid, the previous window is kept and `win_err` pulses.
- R6: `row_done` pulses with every `rd_stb`. `frame_done` pulses with the read of the bottom row of the window.
- R7: In single-frame mode, `capture_done` pulses together with `frame_done`, and `busy` goes low at that same edge. A new run needs `run` to fall and rise again.
- R8: If `run` goes low while `stop_at_end` is 1, the sequencer finishes at the next bottom-row read and pulses `capture_done` there. No new reset frame starts after the stop request.
- R9: If `run` goes low while `stop_at_end` is 0 and no graceful stop is pending, the next cycle shows `row_done`, `frame_done` and `capture_done` with no strobes, and `busy` goes low.
- R10: A start attempt where `last_row` < aligned first + 3 pulses `win_err` for one cycle and leaves the block idle.
- R11: During reset, every output is 0.
- R12: `rd_en` rises together with the first `rd_stb` of a run. It stays high until one cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_tick | input | 1 | One-cycle pulse, one per row period |
| run | input | 1 | Run request; a rising edge starts a run, a low level stops it |
| continuous | input | 1 | 1 = loop over frames, 0 = single frame (taken at start) |
| stop_at_end | input | 1 | 1 = on stop, finish the current frame first |
| first_row | input | RW | Top row of the window (aligned down to a multiple of 4) |
| last_row | input | RW | Bottom row of the window |
| integ_rows | input | IW | Integration time in row periods |
| rst_stb | output | 1 | Row reset strobe |
| rst_row | output | RW | Row being reset |
| rd_stb | output | 1 | Row read strobe |
| rd_row | output | RW | Row being read |
| rd_en | output | 1 | Gate for pixel output |
| row_done | output | 1 | Row read complete |
| frame_done | output | 1 | Frame complete |
| capture_done | output | 1 | Run complete |
| busy | output | 1 | Run in progress |
| win_err | output | 1 | Invalid window seen |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the integration time never exceeds the depth of the bench's history of reset events. The stimulus drives inputs only between clock edges. It keeps windows inside the row address space and limits integration to at most 30 rows. It mixes frequent invalid windows, changes to the window in the middle of a frame, and both stop styles with random tick density.

// File: rtl/rolling_row_seq_pkg.sv
package rolling_row_seq_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/rss_win_decode.sv
// Window decode: aligns the top row, computes the row count and frame period.
module rss_win_decode #(
  parameter int RW = 10,
  parameter int CW = 12
) (
  input  logic [RW-1:0] first_in,
  input  logic [RW-1:0] last_in,
  input  logic [CW-1:0] k_in,
  output logic [RW-1:0] first_al,
  output logic [CW-1:0] n_rows,
  output logic [CW-1:0] f_ticks,
  output logic          ok
);
  localparam int EW = RW + 1;
  logic [EW-1:0] lo, hi, span;

  always_comb begin
    first_al = first_in & ~RW'(3);
    lo       = {1'b0, first_al};
    hi       = {1'b0, last_in};
    ok       = hi >= (lo + EW'(3));
    span     = hi - lo + EW'(1);
    n_rows   = CW'(span);
    f_ticks  = (n_rows > k_in) ? n_rows : k_in;
  end
endmodule

// File: rtl/rss_reset_ptr.sv
// Reset pointer: walks the window once per frame period.
module rss_reset_ptr #(
  parameter int RW = 10,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic          clear,
  input  logic [RW-1:0] start_first,
  input  logic [CW-1:0] start_n,
  input  logic [CW-1:0] start_f,
  input  logic          allow_next,
  input  logic          nxt_ok,
  input  logic [RW-1:0] nxt_first,
  input  logic [CW-1:0] nxt_n,
  input  logic [CW-1:0] nxt_f,
  output logic          fire,
  output logic [RW-1:0] row,
  output logic          relatch_err,
  output logic [RW-1:0] cur_first,
  output logic [CW-1:0] cur_n,
  output logic [CW-1:0] cur_f
);
  logic          act;
  logic [CW-1:0] idx;
  logic          at_end;

  always_comb begin
    at_end      = (idx == cur_f - CW'(1));
    fire        = step && act && (idx < cur_n);
    row         = cur_first + idx[RW-1:0];
    relatch_err = step && act && at_end && allow_next && !nxt_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= 1'b0;
      idx       <= '0;
      cur_first <= '0;
      cur_n     <= '0;
      cur_f     <= '0;
    end else if (clear) begin
      act <= 1'b0;
      idx <= '0;
    end else if (start) begin
      act       <= 1'b1;
      idx       <= '0;
      cur_first <= start_first;
      cur_n     <= start_n;
      cur_f     <= start_f;
    end else if (step && act) begin
      if (at_end) begin
        idx <= '0;
        if (allow_next) begin
          if (nxt_ok) begin
            cur_first <= nxt_first;
            cur_n     <= nxt_n;
            cur_f     <= nxt_f;
          end
        end else begin
          act <= 1'b0;
        end
      end else begin
        idx <= idx + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rss_read_ptr.sv
// Read pointer: waits out the integration time, then trails the reset pointer.
module rss_read_ptr #(
  parameter int RW = 10,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic          clear,
  input  logic [CW-1:0] k,
  input  logic [RW-1:0] start_first,
  input  logic [CW-1:0] start_n,
  input  logic [CW-1:0] start_f,
  input  logic [RW-1:0] src_first,
  input  logic [CW-1:0] src_n,
  input  logic [CW-1:0] src_f,
  output logic          fire,
  output logic [RW-1:0] row,
  output logic          bottom
);
  logic          on;
  logic [CW-1:0] warm, idx, n_q, f_q;
  logic [RW-1:0] first_q;
  logic          at_end;

  always_comb begin
    at_end = (idx == f_q - CW'(1));
    fire   = step && on && (idx < n_q);
    bottom = fire && (idx == n_q - CW'(1));
    row    = first_q + idx[RW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on      <= 1'b0;
      warm    <= '0;
      idx     <= '0;
      first_q <= '0;
      n_q     <= '0;
      f_q     <= '0;
    end else if (clear) begin
      on   <= 1'b0;
      warm <= '0;
      idx  <= '0;
    end else if (start) begin
      on      <= 1'b0;
      warm    <= '0;
      idx     <= '0;
      first_q <= start_first;
      n_q     <= start_n;
      f_q     <= start_f;
    end else if (step) begin
      if (!on) begin
        warm <= warm + CW'(1);
        if (warm == k - CW'(1)) on <= 1'b1;
      end else if (at_end) begin
        idx     <= '0;
        first_q <= src_first;
        n_q     <= src_n;
        f_q     <= src_f;
      end else begin
        idx <= idx + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rolling_row_seq.sv
module rolling_row_seq
  import rolling_row_seq_pkg::*;
#(
  parameter int RW = 10,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_tick,
  input  logic          run,
  input  logic          continuous,
  input  logic          stop_at_end,
  input  logic [RW-1:0] first_row,
  input  logic [RW-1:0] last_row,
  input  logic [IW-1:0] integ_rows,
  output logic          rst_stb,
  output logic [RW-1:0] rst_row,
  output logic          rd_stb,
  output logic [RW-1:0] rd_row,
  output logic          rd_en,
  output logic          row_done,
  output logic          frame_done,
  output logic          capture_done,
  output logic          busy,
  output logic          win_err
);
  localparam int CW = ((RW + 1) > IW) ? (RW + 1) : IW;

  seq_state_e    state_q;
  logic          run_q, cont_q, pend_q;
  logic [CW-1:0] k_q, k_start;

  logic [RW-1:0] s_first, n_first;
  logic [CW-1:0] s_n, s_f, n_n, n_f;
  logic          s_ok, n_ok;

  logic          run_rise, start, start_bad, abort, pend_set, step;
  logic          allow_next, finish, seq_clear;
  logic          rs_fire, rs_err, rp_fire, rp_bottom;
  logic [RW-1:0] rs_row, rp_row, cur_first;
  logic [CW-1:0] cur_n, cur_f;

  assign busy = (state_q == SEQ_RUN);

  always_comb begin
    k_start    = (integ_rows == '0) ? CW'(1) : CW'(integ_rows);
    run_rise   = run && !run_q;
    start      = !busy && run_rise && s_ok;
    start_bad  = !busy && run_rise && !s_ok;
    abort      = busy && !run && !pend_q && !stop_at_end;
    pend_set   = busy && !run && stop_at_end;
    step       = busy && row_tick && !abort;
    allow_next = cont_q && !pend_q && !pend_set;
    finish     = rp_bottom && (!cont_q || pend_q || pend_set);
    seq_clear  = abort || finish;
  end

  rss_win_decode #(.RW(RW), .CW(CW)) u_dec_start (
    .first_in(first_row), .last_in(last_row), .k_in(k_start),
    .first_al(s_first), .n_rows(s_n), .f_ticks(s_f), .ok(s_ok)
  );

  rss_win_decode #(.RW(RW), .CW(CW)) u_dec_next (
    .first_in(first_row), .last_in(last_row), .k_in(k_q),
    .first_al(n_first), .n_rows(n_n), .f_ticks(n_f), .ok(n_ok)
  );

  rss_reset_ptr #(.RW(RW), .CW(CW)) u_rst_ptr (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .clear(seq_clear),
    .start_first(s_first), .start_n(s_n), .start_f(s_f),
    .allow_next(allow_next), .nxt_ok(n_ok),
    .nxt_first(n_first), .nxt_n(n_n), .nxt_f(n_f),
    .fire(rs_fire), .row(rs_row), .relatch_err(rs_err),
    .cur_first(cur_first), .cur_n(cur_n), .cur_f(cur_f)
  );

  rss_read_ptr #(.RW(RW), .CW(CW)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .clear(seq_clear),
    .k(k_q), .start_first(s_first), .start_n(s_n), .start_f(s_f),
    .src_first(cur_first), .src_n(cur_n), .src_f(cur_f),
    .fire(rp_fire), .row(rp_row), .bottom(rp_bottom)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      run_q   <= 1'b0;
      cont_q  <= 1'b0;
      pend_q  <= 1'b0;
      k_q     <= CW'(1);
    end else begin
      run_q <= run;
      if (start) begin
        state_q <= SEQ_RUN;
        cont_q  <= continuous;
        k_q     <= k_start;
        pend_q  <= 1'b0;
      end else if (seq_clear) begin
        state_q <= SEQ_IDLE;
        pend_q  <= 1'b0;
      end else if (pend_set) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_stb      <= 1'b0;
      rst_row      <= '0;
      rd_stb       <= 1'b0;
      rd_row       <= '0;
      rd_en        <= 1'b0;
      row_done     <= 1'b0;
      frame_done   <= 1'b0;
      capture_done <= 1'b0;
      win_err      <= 1'b0;
    end else begin
      rst_stb <= rs_fire;
      if (rs_fire) rst_row <= rs_row;
      rd_stb <= rp_fire;
      if (rp_fire) rd_row <= rp_row;
      rd_en        <= busy ? (rd_en || rp_fire) : 1'b0;
      row_done     <= abort || rp_fire;
      frame_done   <= abort || rp_bottom;
      capture_done <= seq_clear;
      win_err      <= start_bad || rs_err;
    end
  end
endmodule

// File: rtl/rolling_row_seq_chk.sv
module rolling_row_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic rst_stb,
  input logic rd_stb,
  input logic rd_en,
  input logic row_done,
  input logic frame_done,
  input logic capture_done,
  input logic busy,
  input logic win_err
);
  // R1: a run only begins after run was requested
  a_r1_start_on_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run));
  // R2: resets happen only inside a run
  a_r2_reset_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb |-> $past(busy));
  // R6: frame end always carries a row event
  a_r6_frame_has_row: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> row_done);
  // R7: capture end carries frame end and leaves the block idle
  a_r7_capture_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
    capture_done |-> frame_done);
  a_r7_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
    capture_done |-> !busy);
  // R9: an abrupt frame end has no strobes
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !rd_stb) |-> (!rst_stb && !busy));
  // R10: a rejected start stays idle
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (win_err && !$past(busy)) |-> !busy);
  // R12: reads are gated by rd_en, which is low after an idle cycle
  a_r12_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> rd_en);
  a_r12_en_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy) |-> !rd_en);
endmodule

bind rolling_row_seq rolling_row_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .rst_stb(rst_stb), .rd_stb(rd_stb),
  .rd_en(rd_en), .row_done(row_done), .frame_done(frame_done),
  .capture_done(capture_done), .busy(busy), .win_err(win_err)
);

// File: tb/rolling_row_seq_tb.sv
module rolling_row_seq_tb;
  localparam int RW = 10;
  localparam int IW = 12;

  logic clk = 1'b0, rst_n = 1'b0, row_tick = 1'b0, run = 1'b0;
  logic continuous = 1'b0, stop_at_end = 1'b0;
  logic [RW-1:0] first_row = '0, last_row = '0;
  logic [IW-1:0] integ_rows = '0;
  logic rst_stb, rd_stb, rd_en, row_done, frame_done, capture_done, busy, win_err;
  logic [RW-1:0] rst_row, rd_row;

  rolling_row_seq #(.RW(RW), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_tick(row_tick), .run(run),
    .continuous(continuous), .stop_at_end(stop_at_end),
    .first_row(first_row), .last_row(last_row), .integ_rows(integ_rows),
    .rst_stb(rst_stb), .rst_row(rst_row), .rd_stb(rd_stb), .rd_row(rd_row),
    .rd_en(rd_en), .row_done(row_done), .frame_done(frame_done),
    .capture_done(capture_done), .busy(busy), .win_err(win_err)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tick_pct = 100;
  string tag = "R11";

  // reference model state
  bit m_busy, m_runq, m_cont, m_pend, r_act;
  int m_k, m_j, r_idx, r_first, r_n, r_f;
  bit h_v [1024];
  int h_row [1024];
  bit h_bot [1024];
  int e_rst_stb, e_rst_row, e_rd_stb, e_rd_row, e_rd_en, e_row, e_frame, e_cap, e_err;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string req, int act, int exp, string name);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: actual=%0d expected=%0d", req, tag, name, act, exp);
    end
  endtask

  task automatic model_edge();
    int fa, lastv;
    bit ok, rr, start, bad, abort, pset, step, allow, rdfire, bot, fin;
    fa = int'(first_row) & ~3;
    lastv = int'(last_row);
    ok = lastv >= fa + 3;
    rr = run && !m_runq;
    start = !m_busy && rr && ok;
    bad = !m_busy && rr && !ok;
    abort = m_busy && !run && !m_pend && !stop_at_end;
    pset = m_busy && !run && stop_at_end;
    step = m_busy && row_tick && !abort;
    e_rst_stb = 0; e_rd_stb = 0; e_err = int'(bad); rdfire = 0; bot = 0;
    if (step) begin
      int slot;
      slot = m_j % 1024;
      h_v[slot] = 0;
      if (r_act) begin
        if (r_idx < r_n) begin
          e_rst_stb = 1; e_rst_row = r_first + r_idx;
          h_v[slot] = 1; h_row[slot] = e_rst_row; h_bot[slot] = (r_idx == r_n - 1);
        end
        if (r_idx == r_f - 1) begin
          r_idx = 0;
          allow = m_cont && !m_pend && !pset;
          if (allow) begin
            if (ok) begin
              r_first = fa; r_n = lastv - fa + 1; r_f = max2(r_n, m_k);
            end else e_err = 1;
          end else r_act = 0;
        end else r_idx++;
      end
      if (m_j >= m_k) begin
        int s2;
        s2 = (m_j - m_k) % 1024;
        if (h_v[s2]) begin rdfire = 1; e_rd_row = h_row[s2]; bot = h_bot[s2]; end
      end
      m_j++;
    end
    e_rd_stb = int'(rdfire);
    e_row = int'(abort || rdfire);
    e_frame = int'(abort || bot);
    fin = bot && (!m_cont || m_pend || pset);
    e_cap = int'(abort || fin);
    e_rd_en = m_busy ? int'((e_rd_en != 0) || rdfire) : 0;
    if (start) begin
      m_busy = 1; m_cont = continuous; m_pend = 0; m_j = 0;
      m_k = (integ_rows == '0) ? 1 : int'(integ_rows);
      r_act = 1; r_idx = 0; r_first = fa; r_n = lastv - fa + 1; r_f = max2(r_n, m_k);
    end else if (abort || fin) begin
      m_busy = 0; m_pend = 0;
    end else if (pset) m_pend = 1;
    m_runq = run;
  endtask

  task automatic compare();
    chk("R2", int'(rst_stb), e_rst_stb, "rst_stb");
    chk("R2", int'(rst_row), e_rst_row, "rst_row");
    chk("R3", int'(rd_stb), e_rd_stb, "rd_stb");
    chk("R3", int'(rd_row), e_rd_row, "rd_row");
    chk("R12", int'(rd_en), e_rd_en, "rd_en");
    chk("R6", int'(row_done), e_row, "row_done");
    chk("R6", int'(frame_done), e_frame, "frame_done");
    chk("R7", int'(capture_done), e_cap, "capture_done");
    chk("R1", int'(busy), int'(m_busy), "busy");
    chk("R10", int'(win_err), e_err, "win_err");
  endtask

  task automatic step_cycle();
    row_tick = ($urandom_range(99) < tick_pct);
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) step_cycle();
  endtask

  task automatic set_win(int f, int l, int k);
    first_row = RW'(f); last_row = RW'(l); integ_rows = IW'(k);
  endtask

  task automatic finish_run();
    run = 1'b0;
    for (int i = 0; i < 3000 && m_busy; i++) step_cycle();
    run_cycles(3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R11: outputs during reset
    tag = "R11";
    run_cycles(3);
    rst_n = 1'b1;
    // R1, R7: single frame, unaligned top row, no restart while run stays high
    tag = "R1"; tick_pct = 100;
    set_win(5, 11, 3); continuous = 0; stop_at_end = 0; run = 1;
    run_cycles(20);
    tag = "R7"; run_cycles(5);
    run = 0; run_cycles(2);
    // R3: zero integration counts as one
    tag = "R3"; set_win(0, 3, 0); run = 1; run_cycles(10); run = 0; run_cycles(2);
    // R4 then R8: frame gap, then graceful stop
    tag = "R4"; continuous = 1; set_win(8, 11, 10); run = 1; run_cycles(35);
    tag = "R8"; stop_at_end = 1; finish_run();
    // R5 then R9: window changes mid-run, invalid relatch, abrupt stop
    tag = "R5"; stop_at_end = 0; set_win(0, 7, 3); run = 1; run_cycles(6);
    set_win(16, 19, 3); run_cycles(12);
    set_win(20, 18, 3); run_cycles(20);
    tag = "R9"; run = 0; run_cycles(3);
    // R10: invalid window at start
    tag = "R10"; set_win(12, 13, 2); run = 1; run_cycles(3); run = 0; run_cycles(2);
    // R2: random runs
    tag = "R2";
    for (int it = 0; it < 40; it++) begin
      int f, l;
      tick_pct = 20 + $urandom_range(80);
      f = $urandom_range(60);
      l = ($urandom_range(9) == 0) ? f + 1 : f + 3 + $urandom_range(20);
      set_win(f, l, $urandom_range(30));
      continuous = $urandom_range(1);
      run = 1;
      for (int c = 0; c < 20 + $urandom_range(280); c++) begin
        if ($urandom_range(49) == 0) begin
          f = $urandom_range(60);
          set_win(f, f + $urandom_range(22), $urandom_range(30));
        end
        step_cycle();
      end
      stop_at_end = $urandom_range(1);
      finish_run();
      stop_at_end = 0;
    end
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule